// File: doc/BRIEF.md
# Run-Length Sample Packer

This block sits between a sampled signal bundle and the capture memory of an on-chip logic analyser. On every cycle where its clock enable is high it takes one 31-bit sample. Instead of storing each sample, it stores a literal word when the value is new and a repeat-count word when the value holds. Each word it produces is 32 bits wide and goes to the memory with a one-cycle write strobe.

A word with bit 31 clear carries a sample in bits 30:0. A word with bit 31 set says that the most recent literal repeats N+1 more times, where N is the value in bits 30:0. A trigger input forces the current sample to be recorded as a literal, so that the trigger instant can be located exactly in the decoded stream. The block emits at most one word per enabled cycle. When a run word and a fresh literal fall due in the same cycle, the literal is held back for one enabled cycle.

Top module: `rle_sample_packer`

## Requirements
- R1: While reset is asserted, and directly after it, `buf_wr` is 0 and `buf_word` is 0.
- R2: `buf_wr` is high only in the cycle after an edge at which `smp_ce` was high. At most one word is written per enabled sample.
- R3: The first enabled sample after reset is written as a literal: bit 31 = 0 and bits 30:0 = the sample.
- R4: An enabled sample that differs from the previous enabled sample always causes a write in the cycle after its edge. It is recorded as a literal, either at once or after one pending cycle (see R9).
- R5: While enabled samples equal the previous one and the repeat count is below its limit, nothing is written. When the value changes, the pending run is written as bit 31 = 1 with bits 30:0 = repeats - 1.
- R6: One repeat is encoded as 0x80000000 and two repeats as 0x80000001.
- R7: When a run already holds RUN_LIMIT+1 repeats and one more equal sample arrives, the word {1, RUN_LIMIT} is written and a new run of one repeat begins.
- R8: An enabled sample with `smp_trig` high ends any pending run, even if the sample equals the previous one. The trigger sample is recorded as a literal.
- R9: If a run word and a literal are due on the same enabled sample, the run word is written first. The literal is written on the next enabled sample.
- R10: Cycles with `smp_ce` low write nothing and leave the compression state unchanged, whatever `smp_data` and `smp_trig` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_ce | input | 1 | Sample enable; the block acts only when high |
| smp_data | input | DW (31) | Sample value |
| smp_trig | input | 1 | Forces the current sample to be stored as a literal |
| buf_word | output | DW+1 (32) | Word to the capture memory |
| buf_wr | output | 1 | Write strobe for `buf_word` |

## Verification
The stream is driven with the following patterns, each chosen to separate one kind of fault:

- Strictly changing values show whether literals pass through unchanged.
- Pairs and triples of equal values pin down the minus-one count encoding.
- A run change right after a run, and a change right after that, expose a lost or reordered deferred literal.
- Long runs with a small repeat limit separate a correct saturation wrap from an off-by-one.
- Triggers on equal samples, both inside a run and with a literal pending, show whether a trigger flushes the run.
- Gaps with the enable low, during which data and trigger toggle, show that idle cycles are ignored.
- A random phase over a small alphabet of values mixes all of the above.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_LIT  = 2'd1,
    WK_PEND = 2'd2,
    WK_RUN  = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/rle_group_detect.sv
module rle_group_detect #(
  parameter int DW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic [DW-1:0] din,
  input  logic          trig,
  output logic          new_grp
);

  logic          have_q, have_d;
  logic [DW-1:0] last_q, last_d;

  assign new_grp = !have_q || (din != last_q) || trig;

  always_comb begin
    have_d = have_q;
    last_d = last_q;
    if (ce) begin
      have_d = 1'b1;
      last_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else begin
      have_q <= have_d;
      last_q <= last_d;
    end
  end

  // R10: idle cycles leave the reference value untouched
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(last_q) && $stable(have_q));

  // R3: once a sample was taken, a reference value exists
  p_have_after_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> have_q);

endmodule

// File: rtl/rle_run_ctr.sv
module rle_run_ctr #(
  parameter int          DW        = 31,
  parameter int unsigned RUN_LIMIT = 32'h7FFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          new_grp,
  output logic          run_on,
  output logic [DW-1:0] run_cnt,
  output logic          sat
);

  localparam logic [DW-1:0] LIM = DW'(RUN_LIMIT);

  logic          on_q, on_d;
  logic [DW-1:0] cnt_q, cnt_d;

  assign run_on  = on_q;
  assign run_cnt = cnt_q;
  assign sat     = on_q && (cnt_q == LIM);

  always_comb begin
    on_d  = on_q;
    cnt_d = cnt_q;
    if (ce) begin
      if (new_grp) begin
        on_d  = 1'b0;
        cnt_d = '0;
      end else if (!on_q) begin
        on_d  = 1'b1;
        cnt_d = '0;
      end else if (sat) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
    end
  end

  // R10: count frozen on idle cycles
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cnt_q) && $stable(on_q));

  // R8: a new group (change or trigger) always closes the run
  p_run_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce && new_grp |=> !on_q);

endmodule

// File: rtl/rle_emit.sv
module rle_emit
  import rle_pkg::*;
#(
  parameter int DW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          new_grp,
  input  logic [DW-1:0] din,
  input  logic          run_on,
  input  logic [DW-1:0] run_cnt,
  input  logic          sat,
  output logic          pend_v,
  output logic [DW:0]   word,
  output logic          wr
);

  wr_kind_e      kind;
  logic          pv_q, pv_d;
  logic [DW-1:0] pd_q, pd_d;
  logic [DW:0]   word_q, word_d;
  logic          wr_q, wr_d;

  assign pend_v = pv_q;
  assign word   = word_q;
  assign wr     = wr_q;

  always_comb begin
    kind = WK_NONE;
    if (new_grp) begin
      if (run_on)      kind = WK_RUN;
      else if (pv_q)   kind = WK_PEND;
      else             kind = WK_LIT;
    end else begin
      if (pv_q)        kind = WK_PEND;
      else if (sat)    kind = WK_RUN;
    end
  end

  always_comb begin
    pv_d   = pv_q;
    pd_d   = pd_q;
    word_d = word_q;
    wr_d   = 1'b0;
    if (ce) begin
      pv_d = new_grp && (run_on || pv_q);
      if (new_grp) pd_d = din;
      case (kind)
        WK_RUN:  word_d = {1'b1, run_cnt};
        WK_PEND: word_d = {1'b0, pd_q};
        WK_LIT:  word_d = {1'b0, din};
        default: word_d = word_q;
      endcase
      wr_d = (kind != WK_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      pd_q   <= '0;
      word_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      pv_q   <= pv_d;
      pd_q   <= pd_d;
      word_q <= word_d;
      wr_q   <= wr_d;
    end
  end

  p_wr_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(ce));

  p_new_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ce && new_grp |=> wr_q);

  p_equal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !new_grp && !pv_q && !sat |=> !wr_q);

  p_sat_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce && !new_grp && !pv_q && sat |=> wr_q && word_q[DW] && (word_q[DW-1:0] == $past(run_cnt)));

  p_pend_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce && pv_q |=> wr_q && !word_q[DW]);

endmodule

// File: rtl/rle_sample_packer.sv
module rle_sample_packer #(
  parameter int          DW        = 31,
  parameter int unsigned RUN_LIMIT = 32'h7FFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_ce,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_trig,
  output logic [DW:0]   buf_word,
  output logic          buf_wr
);

  logic          new_grp;
  logic          run_on;
  logic [DW-1:0] run_cnt;
  logic          sat;
  logic          pend_v;

  rle_group_detect #(.DW(DW)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (smp_ce),
    .din     (smp_data),
    .trig    (smp_trig),
    .new_grp (new_grp)
  );

  rle_run_ctr #(.DW(DW), .RUN_LIMIT(RUN_LIMIT)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (smp_ce),
    .new_grp (new_grp),
    .run_on  (run_on),
    .run_cnt (run_cnt),
    .sat     (sat)
  );

  rle_emit #(.DW(DW)) u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (smp_ce),
    .new_grp (new_grp),
    .din     (smp_data),
    .run_on  (run_on),
    .run_cnt (run_cnt),
    .sat     (sat),
    .pend_v  (pend_v),
    .word    (buf_word),
    .wr      (buf_wr)
  );

  // checker-only flag: has any word been written since reset
  logic seen_wr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_wr_q <= 1'b0;
    else if (buf_wr) seen_wr_q <= 1'b1;
  end

  p_first_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && !seen_wr_q |-> !buf_word[DW]);

  p_trig_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ce && smp_trig |=> buf_wr);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_ce |=> !buf_wr);

  p_no_run_with_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_v && run_on));

endmodule

// File: tb/rle_sample_packer_tb.sv
`timescale 1ns/1ps
module rle_sample_packer_tb_top;

  localparam int DW  = 31;
  localparam int LIM = 4;

  logic          clk;
  logic          rst_n;
  logic          smp_ce;
  logic [DW-1:0] smp_data;
  logic          smp_trig;
  logic [DW:0]   buf_word;
  logic          buf_wr;

  rle_sample_packer #(.DW(DW), .RUN_LIMIT(LIM)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_ce   (smp_ce),
    .smp_data (smp_data),
    .smp_trig (smp_trig),
    .buf_word (buf_word),
    .buf_wr   (buf_wr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference: group state plus a queue of words owed
  bit            m_have = 0;
  logic [DW-1:0] m_last = '0;
  int            m_len  = 0;
  logic [DW:0]   m_q[$];
  bit            exp_wr   = 0;
  logic [DW:0]   exp_word = '0;
  string         exp_tag  = "R1";

  task automatic check_out();
    checks++;
    if (buf_wr !== exp_wr || (exp_wr && buf_word !== exp_word)) begin
      fails++;
      $display("FAIL %s: wr=%0b word=%h expected wr=%0b word=%h",
               exp_tag, buf_wr, buf_word, exp_wr, exp_word);
    end
  endtask

  task automatic model(input bit ce, input logic [DW-1:0] d, input bit t);
    exp_wr = 0;
    if (!ce) return;
    if (!m_have || d != m_last || t) begin
      if (m_have && m_len > 1) m_q.push_back({1'b1, DW'(m_len - 2)});
      m_q.push_back({1'b0, d});
      m_last = d;
      m_len  = 1;
      m_have = 1;
    end else if (m_len - 1 == LIM + 1) begin
      m_q.push_back({1'b1, DW'(LIM)});
      m_len = 2;
    end else begin
      m_len++;
    end
    if (m_q.size() > 0) begin
      exp_wr   = 1;
      exp_word = m_q.pop_front();
    end
  endtask

  task automatic step(input bit ce, input logic [DW-1:0] d, input bit t, input string tag);
    @(negedge clk);
    check_out();
    smp_ce   = ce;
    smp_data = d;
    smp_trig = t;
    model(ce, d, t);
    exp_tag = tag;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; smp_ce = 0; smp_data = '0; smp_trig = 0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared under reset
    checks++;
    if (buf_wr !== 1'b0 || buf_word !== '0) begin
      fails++;
      $display("FAIL R1: wr=%0b word=%h expected wr=0 word=0", buf_wr, buf_word);
    end
    rst_n = 1;
    exp_tag = "R1";
    step(0, 31'h11, 0, "R1");
    // R3: first sample is a literal
    step(1, 31'h5, 0, "R3");
    // R4: distinct values
    step(1, 31'h6, 0, "R4");
    step(1, 31'h7, 0, "R4");
    step(1, 31'h7FFF_FFFF, 0, "R4");
    // R6: one repeat -> 0x80000000, two -> 0x80000001
    step(1, 31'h9, 0, "R6");
    step(1, 31'h9, 0, "R5");
    step(1, 31'hA, 0, "R6");
    step(1, 31'hB, 0, "R9");
    step(1, 31'hB, 0, "R5");
    step(1, 31'hB, 0, "R5");
    step(1, 31'hC, 0, "R6");
    // R9: run word collides with literal, then immediate change
    step(1, 31'hD, 0, "R9");
    step(1, 31'hD, 0, "R9");
    step(1, 31'hE, 0, "R9");
    step(1, 31'hF, 0, "R9");
    // R10: idle cycles with noisy data and trigger
    step(1, 31'h20, 0, "R10");
    step(0, 31'h55, 1, "R10");
    step(0, 31'h66, 0, "R10");
    step(1, 31'h20, 0, "R10");
    step(0, 31'h20, 1, "R10");
    step(1, 31'h20, 0, "R10");
    step(1, 31'h21, 0, "R10");
    // R7: long run across the repeat limit
    for (int i = 0; i < 14; i++) step(1, 31'h30, 0, "R7");
    step(1, 31'h31, 0, "R7");
    step(1, 31'h32, 0, "R7");
    // R8: trigger inside a run, on a repeat with no run, and with a literal pending
    step(1, 31'h40, 0, "R8");
    step(1, 31'h40, 0, "R8");
    step(1, 31'h40, 0, "R8");
    step(1, 31'h40, 1, "R8");
    step(1, 31'h40, 0, "R8");
    step(1, 31'h41, 0, "R8");
    step(1, 31'h41, 1, "R8");
    step(1, 31'h42, 0, "R8");
    step(1, 31'h42, 0, "R8");
    step(1, 31'h43, 0, "R8");
    step(1, 31'h43, 1, "R8");
    step(1, 31'h44, 0, "R8");
    // mixed random traffic: R2 R5 R7 R8 R9 R10 together
    for (int i = 0; i < 400; i++) begin
      logic [DW-1:0] v;
      v = DW'($urandom_range(0, 2));
      step(($urandom_range(0, 4) != 0), v, ($urandom_range(0, 15) == 0), "R2");
    end
    for (int i = 0; i < 3; i++) step(0, '0, 0, "R2");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule